// File: doc/BRIEF.md
# Lane Permute Unit

This block reorders the lanes of two wide source operands (A and B) into one result of the same width. An operation code picks the shuffle. The shuffles are pack, interleave, broadcast, copy and rotate, each with a fixed lane order. The block never changes a lane's value, only where the lane ends up.

The result is registered. It appears one clock after the request, together with a write enable and the destination index it belongs to. A destination index of zero and any unknown operation code both leave the write enable low.

The width is a parameter that must be a multiple of 64. In the text below, "word" means a quarter of the data width and "half" means 64 bits at the default width. The examples assume the default of 128 bits. Lanes are numbered from the least significant end.

Top module: `lane_permute_unit`

## Requirements
- R1: Operation code 0 (pack) gives {A.w2, A.w0, B.w2, B.w0}, listed from the top word down.
- R2: Operation codes 1, 2 and 3 interleave the low halves of A and B at byte, halfword and word width. Result lane 2i is lane i of B and result lane 2i+1 is lane i of A.
- R3: Operation code 4 does the same word interleave using the high halves, giving {A.w3, B.w3, A.w2, B.w2}.
- R4: Operation code 5 takes halfword 0 of each half of B and copies it into all four halfwords of that half.
- R5: Operation code 6 gives {A.low half, B.low half}.
- R6: Operation code 7 gives {B.high half, A.high half}.
- R7: Operation code 8 maps the words {w3, w2, w1, w0} of B to {w3, w0, w2, w1}.
- R8: A request with destination 0 raises no write, and out_data and out_dest keep their values.
- R9: Operation codes 9 to 15 raise no write, and out_data and out_dest keep their values.
- R10: For an accepted request, out_we goes high for exactly the next cycle, and out_dest carries the request's index.
- R11: During reset, out_we, out_dest and out_data are all zero.
- R12: While in_valid is low, out_we is low and out_data and out_dest hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_dest | input | IDX_W | Destination index |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand |
| out_we | output | 1 | Write enable, one cycle after an accepted request |
| out_dest | output | IDX_W | Destination index of the result |
| out_data | output | DATA_W | Registered result |

## Verification
The bench uses operands whose lanes all differ, so a lane out of place shows up as a wrong value. A design that swaps the even and odd interleave slots, or takes the high half instead of the low half, produces a result that differs from the expected one.

A rotate that moves word 3 fails the R7 check. A broadcast that takes its source from A instead of B fails the R4 check.

Requests with destination zero and requests with unused operation codes are mixed in at random. A design that writes anyway raises out_we when it must not, or overwrites the held data, and both are caught.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_PACK_EVEN  = 4'd0,
      OP_ILV_LO_B   = 4'd1,
      OP_ILV_LO_H   = 4'd2,
      OP_ILV_LO_W   = 4'd3,
      OP_ILV_HI_W   = 4'd4,
      OP_BCAST_H    = 4'd5,
      OP_COPY_LO    = 4'd6,
      OP_COPY_HI    = 4'd7,
      OP_ROT3_W     = 4'd8
   } lpu_op_e;

   localparam logic [OP_W-1:0] LAST_OP = OP_ROT3_W;
endpackage

// File: rtl/lpu_interleave.sv
// Alternates lanes of two half-width inputs: B lane in even slot, A lane in odd slot.
module lpu_interleave #(
   parameter int HALF_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [HALF_W-1:0]   half_a,
   input  logic [HALF_W-1:0]   half_b,
   output logic [2*HALF_W-1:0] merged
);
   localparam int N_LANES = HALF_W / LANE_W;

   initial begin
      assert (HALF_W % LANE_W == 0)
         else $fatal(1, "lane width must divide half width");
   end

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      assign merged[(2*i)*LANE_W   +: LANE_W] = half_b[i*LANE_W +: LANE_W];
      assign merged[(2*i+1)*LANE_W +: LANE_W] = half_a[i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/lpu_lane_ops.sv
// Pack, broadcast, copy and rotate shuffles.
module lpu_lane_ops #(
   parameter int DATA_W = 128
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] r_pack,
   output logic [DATA_W-1:0] r_bcast,
   output logic [DATA_W-1:0] r_copy_lo,
   output logic [DATA_W-1:0] r_copy_hi,
   output logic [DATA_W-1:0] r_rot3
);
   localparam int HALF_W = DATA_W / 2;
   localparam int WORD_W = DATA_W / 4;
   localparam int HW_W   = HALF_W / 4;

   logic [WORD_W-1:0] aw [4];
   logic [WORD_W-1:0] bw [4];

   for (genvar k = 0; k < 4; k++) begin : g_split
      assign aw[k] = op_a[k*WORD_W +: WORD_W];
      assign bw[k] = op_b[k*WORD_W +: WORD_W];
   end

   assign r_pack    = {aw[2], aw[0], bw[2], bw[0]};
   assign r_copy_lo = {op_a[HALF_W-1:0], op_b[HALF_W-1:0]};
   assign r_copy_hi = {op_b[DATA_W-1:HALF_W], op_a[DATA_W-1:HALF_W]};
   assign r_rot3    = {bw[3], bw[0], bw[2], bw[1]};

   for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar q = 0; q < 4; q++) begin : g_quart
         assign r_bcast[h*HALF_W + q*HW_W +: HW_W] = op_b[h*HALF_W +: HW_W];
      end
   end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
   import lpu_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [IDX_W-1:0]  in_dest,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              out_we,
   output logic [IDX_W-1:0]  out_dest,
   output logic [DATA_W-1:0] out_data
);
   localparam int HALF_W = DATA_W / 2;
   localparam int N_ILV  = 4;

   initial begin
      assert (DATA_W >= 64 && DATA_W % 64 == 0)
         else $fatal(1, "DATA_W must be a nonzero multiple of 64");
      assert (IDX_W >= 1)
         else $fatal(1, "IDX_W must be at least 1");
   end

   // Interleave variants: 0..2 low half at byte/halfword/word, 3 high half word
   logic [DATA_W-1:0] ilv_res [N_ILV];

   for (genvar g = 0; g < N_ILV; g++) begin : g_ilv
      localparam int LW = (g == 0) ? HALF_W/8 : (g == 1) ? HALF_W/4 : HALF_W/2;
      localparam int HB = (g == 3) ? HALF_W : 0;
      lpu_interleave #(.HALF_W(HALF_W), .LANE_W(LW)) u_ilv (
         .half_a (src_a[HB +: HALF_W]),
         .half_b (src_b[HB +: HALF_W]),
         .merged (ilv_res[g])
      );
   end

   logic [DATA_W-1:0] r_pack, r_bcast, r_copy_lo, r_copy_hi, r_rot3;

   lpu_lane_ops #(.DATA_W(DATA_W)) u_ops (
      .op_a      (src_a),
      .op_b      (src_b),
      .r_pack    (r_pack),
      .r_bcast   (r_bcast),
      .r_copy_lo (r_copy_lo),
      .r_copy_hi (r_copy_hi),
      .r_rot3    (r_rot3)
   );

   logic [DATA_W-1:0] sel_res;
   logic              op_known;

   always_comb begin
      op_known = 1'b1;
      sel_res  = '0;
      case (lpu_op_e'(in_op))
         OP_PACK_EVEN: sel_res = r_pack;
         OP_ILV_LO_B:  sel_res = ilv_res[0];
         OP_ILV_LO_H:  sel_res = ilv_res[1];
         OP_ILV_LO_W:  sel_res = ilv_res[2];
         OP_ILV_HI_W:  sel_res = ilv_res[3];
         OP_BCAST_H:   sel_res = r_bcast;
         OP_COPY_LO:   sel_res = r_copy_lo;
         OP_COPY_HI:   sel_res = r_copy_hi;
         OP_ROT3_W:    sel_res = r_rot3;
         default:      op_known = 1'b0;
      endcase
   end

   logic do_write;
   assign do_write = in_valid && op_known && (in_dest != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_we   <= 1'b0;
         out_dest <= '0;
         out_data <= '0;
      end else begin
         out_we <= do_write;
         if (do_write) begin
            out_dest <= in_dest;
            out_data <= sel_res;
         end
      end
   end
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker
   import lpu_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        in_op,
   input logic [IDX_W-1:0]  in_dest,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic              out_we,
   input logic [IDX_W-1:0]  out_dest,
   input logic [DATA_W-1:0] out_data
);
   localparam int HALF_W = DATA_W / 2;
   localparam int WORD_W = DATA_W / 4;

   logic op_in_range;
   assign op_in_range = (in_op <= LAST_OP);

   assert_dest_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dest == '0) |=> (!out_we && $stable(out_data) && $stable(out_dest)));

   assert_bad_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_in_range) |=> (!out_we && $stable(out_data)));

   assert_dest_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_in_range && in_dest != '0) |=> (out_we && out_dest == $past(in_dest)));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_we && $stable(out_data) && $stable(out_dest)));

   assert_copy_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_COPY_LO && in_dest != '0) |=>
      (out_data == {$past(src_a[HALF_W-1:0]), $past(src_b[HALF_W-1:0])}));

   assert_rot3_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_ROT3_W && in_dest != '0) |=>
      (out_data[DATA_W-1 -: WORD_W] == $past(src_b[DATA_W-1 -: WORD_W])));
endmodule

bind lane_permute_unit lpu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_op    (in_op),
   .in_dest  (in_dest),
   .src_a    (src_a),
   .src_b    (src_b),
   .out_we   (out_we),
   .out_dest (out_dest),
   .out_data (out_data)
);

// File: tb/sim_lane_permute_unit.sv
`timescale 1ns/1ps
module sim_lane_permute_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   in_op = '0;
   logic [4:0]   in_dest = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         out_we;
   logic [4:0]   out_dest;
   logic [127:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [127:0] exp_data = '0;
   logic [4:0]   exp_dest = '0;

   always #2.5 clk = ~clk;

   lane_permute_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_dest(in_dest), .src_a(src_a), .src_b(src_b),
      .out_we(out_we), .out_dest(out_dest), .out_data(out_data)
   );

   function automatic logic [31:0] wd(logic [127:0] v, int k);
      return v[k*32 +: 32];
   endfunction

   // lane-alternating merge of 64-bit halves at lane width w
   function automatic logic [127:0] ilv(logic [63:0] a, logic [63:0] b, int w);
      logic [127:0] r;
      for (int j = 0; j < 128; j++) begin
         int k = j / w;
         int p = j % w;
         r[j] = (k % 2 == 1) ? a[(k/2)*w + p] : b[(k/2)*w + p];
      end
      return r;
   endfunction

   function automatic logic [127:0] model(logic [3:0] op, logic [127:0] a, logic [127:0] b);
      case (op)
         4'd0: return {wd(a,2), wd(a,0), wd(b,2), wd(b,0)};
         4'd1: return ilv(a[63:0], b[63:0], 8);
         4'd2: return ilv(a[63:0], b[63:0], 16);
         4'd3: return ilv(a[63:0], b[63:0], 32);
         4'd4: return {wd(a,3), wd(b,3), wd(a,2), wd(b,2)};
         4'd5: return {{4{b[79:64]}}, {4{b[15:0]}}};
         4'd6: return {a[63:0], b[63:0]};
         4'd7: return {b[127:64], a[127:64]};
         default: return {wd(b,3), wd(b,0), wd(b,2), wd(b,1)};
      endcase
   endfunction

   function automatic string tag(logic [3:0] op, logic [4:0] d);
      if (op > 4'd8) return "R9";
      if (d == 0) return "R8";
      case (op)
         4'd0: return "R1";
         4'd1, 4'd2, 4'd3: return "R2";
         4'd4: return "R3";
         4'd5: return "R4";
         4'd6: return "R5";
         4'd7: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, result visible after next posedge, sampled at next negedge
   task automatic issue(logic v, logic [3:0] op, logic [4:0] d,
                        logic [127:0] a, logic [127:0] b);
      logic wr;
      in_valid = v; in_op = op; in_dest = d; src_a = a; src_b = b;
      wr = v && op <= 4'd8 && d != 0;
      if (wr) begin
         exp_data = model(op, a, b);
         exp_dest = d;
      end
      @(negedge clk);
      check(v ? tag(op, d) : "R12", {127'd0, out_we}, {127'd0, wr});
      check(v ? tag(op, d) : "R12", out_data, exp_data);
      check(wr ? "R10" : (v ? tag(op, d) : "R12"), {123'd0, out_dest}, {123'd0, exp_dest});
   endtask

   logic [127:0] pa = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
   logic [127:0] pb = 128'h1f1e1d1c_1b1a1918_17161514_13121110;

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", {126'd0, out_we, 1'b0}, 128'd0);
      check("R11", out_data, 128'd0);
      check("R11", {123'd0, out_dest}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed: every supported op on distinct-lane operands
      for (int op = 0; op <= 8; op++) issue(1'b1, op[3:0], 5'd3, pa, pb);
      issue(1'b1, 4'd6, 5'd0, ~pa, ~pb);     // R8
      issue(1'b1, 4'd9, 5'd7, ~pa, ~pb);     // R9
      issue(1'b1, 4'd15, 5'd31, ~pa, ~pb);   // R9
      issue(1'b0, 4'd6, 5'd4, ~pa, ~pb);     // R12
      issue(1'b1, 4'd8, 5'd31, ~pa, pb);     // R7, top index
      issue(1'b1, 4'd5, 5'd1, pa, ~pb);      // R4
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [127:0] ra, rb;
         logic [4:0]   rd;
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         rd = ($urandom % 6 == 0) ? 5'd0 : 5'($urandom);
         issue(($urandom % 8) != 0, 4'($urandom), rd, ra, rb);
      end
      in_valid = 1'b0;
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule